// File: doc/BRIEF.md
# Collision Backoff Timer Controller

This block decides when a carrier-sense transmitter that detected a collision may try again. On each accepted collision it captures a backoff length, given in slot times, from an input port. It counts that length down by one on each slot-time tick and blocks transmission while the count is nonzero. A mode input selects what starts the countdown. In normal mode it starts when the line goes idle. In alternate mode it starts only once the interframe spacing (IFS) has elapsed.

An eight-bit attempt history records retries. Each collision pushes a one into it from the least significant end. When a one is about to fall out of the top, the retry is abandoned. The retry is also abandoned if the transmit FIFO had already been touched by the transmit logic when the collision arrived. An abandoned retry drops transmit-enable and raises a sticky error flag. After that, software must re-enable the transmitter.

The controller is a four-state machine:
- `ST_IDLE`: no backoff pending.
- `ST_WAIT`: a backoff has been loaded and waits for its start condition.
- `ST_COUNT`: the countdown is running.
- `ST_HALT`: the transmitter is disabled.

The transitions are:
- IDLE→WAIT on an accepted collision.
- WAIT→COUNT on the start condition with a nonzero count.
- WAIT→IDLE on the start condition with a zero count.
- COUNT→IDLE on the tick that takes the count from 1 to 0.
- WAIT/COUNT→WAIT when a new accepted collision reloads the count.
- Any non-halted state→HALT on an aborting collision.
- HALT→IDLE on a software re-enable strobe.

Top module: `cbk_timer`

## Requirements
- R1: After reset, transmit-enable is 1, the error flag is 0, the backoff count is 0 and the state is idle.
- R2: A collision that does not abort loads `preload_i` into the count on the next cycle and enters the wait state. This applies from idle, wait or count.
- R3: In the count state, each `slot_tick_i` lowers the count by exactly one, and the count holds between ticks. The tick that reaches 0 returns the block to idle.
- R4: `tx_permit_o` is 1 only when the block is idle, transmit-enable is 1, the count is 0 and `ifs_done_i` is 1. It is 0 whenever the count is nonzero.
- R5: In the wait state, the countdown starts on `line_idle_i` when `alt_mode_i`=0, and on `ifs_done_i` when `alt_mode_i`=1. The other input has no effect, and the count holds until the start condition occurs.
- R6: Each collision shifts a 1 into bit 0 of the attempt history. A collision that finds bit 7 already set aborts: transmit-enable goes to 0, the error flag goes to 1 and the count goes to 0. While the block is halted, collisions are ignored. So, from a cleared history, the ninth collision aborts.
- R7: A collision while `fifo_touched_i`=1 aborts in the same way as R6.
- R8: The error flag stays at 1 until an `err_clr_i` strobe clears it. If an abort and a clear fall in the same cycle, the flag is set.
- R9: `tx_done_i` or `tx_en_set_i` clears the attempt history unless a collision occurs in the same cycle. `tx_en_set_i` while halted returns the block to idle with transmit-enable at 1.
- R10: The count has no software write path. `tx_en_set_i` and `err_clr_i` leave a running count unchanged.
- R11: In alternate mode with a preload of 0, `tx_permit_o` rises in the first cycle after `ifs_done_i` is sampled high in the wait state, provided `ifs_done_i` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_mode_i | input | 1 | 0: start the countdown on line idle; 1: start after IFS |
| coll_i | input | 1 | Collision strobe |
| line_idle_i | input | 1 | Line idle detected |
| ifs_done_i | input | 1 | Interframe spacing has elapsed |
| fifo_touched_i | input | 1 | The transmit FIFO was accessed by the transmit logic |
| slot_tick_i | input | 1 | One pulse per slot time |
| preload_i | input | 8 | Backoff length in slots |
| tx_done_i | input | 1 | Successful transmission strobe |
| tx_en_set_i | input | 1 | Software re-enable strobe |
| err_clr_i | input | 1 | Write-one-to-clear strobe for the error flag |
| tx_en_o | output | 1 | Transmitter enabled |
| tx_permit_o | output | 1 | Transmission may start now |
| err_o | output | 1 | Sticky retry-abandoned flag |
| bkoff_cnt_o | output | 8 | Current backoff count (read only) |

## Verification
Several functions can land in the same cycle:
- a collision together with a slot tick during the countdown, where the reload must win over the decrement;
- a collision together with `tx_done_i`, where the shift must win over the history clear;
- an aborting collision together with `err_clr_i`, where the flag must end up set.

The bench provokes each of these by asserting the strobes in one cycle. A behavioural model applies the stated priorities, and the count, enable, permit and error outputs are compared against that model after every clock.

// File: rtl/cbk_pkg.sv
package cbk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_COUNT = 2'd2,
        ST_HALT  = 2'd3
    } cbk_state_e;
endpackage

// File: rtl/cbk_attempt_reg.sv
module cbk_attempt_reg #(
    parameter int ATT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift,
    input  logic clr,
    output logic full
);
    logic [ATT_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift) begin
            hist_q <= {hist_q[ATT_W-2:0], 1'b1};
        end else if (clr) begin
            hist_q <= '0;
        end
    end

    assign full = hist_q[ATT_W-1];
endmodule

// File: rtl/cbk_slot_counter.sv
module cbk_slot_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             zero,
    output logic             one
);
    localparam logic [CNT_W-1:0] ONE_VAL = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - ONE_VAL;
        end
    end

    assign zero = (cnt == '0);
    assign one  = (cnt == ONE_VAL);
endmodule

// File: rtl/cbk_ctrl_fsm.sv
module cbk_ctrl_fsm
    import cbk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alt_mode,
    input  logic       coll,
    input  logic       line_idle,
    input  logic       ifs_done,
    input  logic       fifo_touched,
    input  logic       slot_tick,
    input  logic       tx_done,
    input  logic       tx_en_set,
    input  logic       att_full,
    input  logic       cnt_zero,
    input  logic       cnt_one,
    output cbk_state_e state,
    output logic       load,
    output logic       dec,
    output logic       clr_cnt,
    output logic       shift,
    output logic       clr_att,
    output logic       abort,
    output logic       tx_en,
    output logic       tx_permit
);
    cbk_state_e state_d;
    logic       live_coll;
    logic       start_ok;

    assign live_coll = coll && (state != ST_HALT);
    assign start_ok  = alt_mode ? ifs_done : line_idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        state_d = state;
        if (live_coll && (fifo_touched || att_full)) begin
            state_d = ST_HALT;
        end else if (live_coll) begin
            state_d = ST_WAIT;
        end else begin
            unique case (state)
                ST_IDLE:  state_d = ST_IDLE;
                ST_WAIT:  if (start_ok) state_d = cnt_zero ? ST_IDLE : ST_COUNT;
                ST_COUNT: if (slot_tick && cnt_one) state_d = ST_IDLE;
                ST_HALT:  if (tx_en_set) state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        abort     = live_coll && (fifo_touched || att_full);
        load      = live_coll && !abort;
        clr_cnt   = abort;
        dec       = (state == ST_COUNT) && slot_tick && !live_coll;
        shift     = live_coll;
        clr_att   = (tx_done || tx_en_set) && !live_coll;
        tx_en     = (state != ST_HALT);
        tx_permit = (state == ST_IDLE) && ifs_done;
    end
endmodule

// File: rtl/cbk_timer.sv
module cbk_timer
    import cbk_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int ATT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alt_mode_i,
    input  logic             coll_i,
    input  logic             line_idle_i,
    input  logic             ifs_done_i,
    input  logic             fifo_touched_i,
    input  logic             slot_tick_i,
    input  logic [CNT_W-1:0] preload_i,
    input  logic             tx_done_i,
    input  logic             tx_en_set_i,
    input  logic             err_clr_i,
    output logic             tx_en_o,
    output logic             tx_permit_o,
    output logic             err_o,
    output logic [CNT_W-1:0] bkoff_cnt_o
);
    cbk_state_e       state_q;
    logic             att_full;
    logic             cnt_zero, cnt_one;
    logic             load, dec, clr_cnt, shift, clr_att, abort;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;

    cbk_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .alt_mode     (alt_mode_i),
        .coll         (coll_i),
        .line_idle    (line_idle_i),
        .ifs_done     (ifs_done_i),
        .fifo_touched (fifo_touched_i),
        .slot_tick    (slot_tick_i),
        .tx_done      (tx_done_i),
        .tx_en_set    (tx_en_set_i),
        .att_full     (att_full),
        .cnt_zero     (cnt_zero),
        .cnt_one      (cnt_one),
        .state        (state_q),
        .load         (load),
        .dec          (dec),
        .clr_cnt      (clr_cnt),
        .shift        (shift),
        .clr_att      (clr_att),
        .abort        (abort),
        .tx_en        (tx_en_o),
        .tx_permit    (tx_permit_o)
    );

    cbk_attempt_reg #(.ATT_W(ATT_W)) u_att (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (shift),
        .clr   (clr_att),
        .full  (att_full)
    );

    cbk_slot_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_cnt),
        .load     (load),
        .load_val (preload_i),
        .dec      (dec),
        .cnt      (cnt_q),
        .zero     (cnt_zero),
        .one      (cnt_one)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (abort) begin
            err_q <= 1'b1;
        end else if (err_clr_i) begin
            err_q <= 1'b0;
        end
    end

    assign err_o       = err_q;
    assign bkoff_cnt_o = cnt_q;
endmodule

// File: rtl/cbk_timer_chk.sv
module cbk_timer_chk
    import cbk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             coll,
    input logic             fifo_touched,
    input logic             slot_tick,
    input logic             err_clr,
    input logic [CNT_W-1:0] preload,
    input cbk_state_e       state,
    input logic             att_full,
    input logic [CNT_W-1:0] cnt,
    input logic             tx_en,
    input logic             tx_permit,
    input logic             err
);
    AST_LOAD_ON_COLL: assert property (@(posedge clk) disable iff (!rst_n)
        (coll && !fifo_touched && !att_full && state != ST_HALT) |=> (cnt == $past(preload))); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT && slot_tick && !coll) |=> (cnt == CNT_W'($past(cnt) - 1'b1))); // R3
    AST_PERMIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tx_permit |-> (cnt == '0 && tx_en)); // R4
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !coll) |=> $stable(cnt)); // R5
    AST_HALT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (cnt == '0)); // R6
    AST_FIFO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (coll && fifo_touched && state != ST_HALT) |=> (err && !tx_en)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err); // R8
endmodule

bind cbk_timer cbk_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .coll         (coll_i),
    .fifo_touched (fifo_touched_i),
    .slot_tick    (slot_tick_i),
    .err_clr      (err_clr_i),
    .preload      (preload_i),
    .state        (state_q),
    .att_full     (att_full),
    .cnt          (cnt_q),
    .tx_en        (tx_en_o),
    .tx_permit    (tx_permit_o),
    .err          (err_q)
);

// File: tb/cbk_timer_test.sv
module cbk_timer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alt_mode_i = 1'b0, coll_i = 1'b0, line_idle_i = 1'b0, ifs_done_i = 1'b0;
    logic       fifo_touched_i = 1'b0, slot_tick_i = 1'b0, tx_done_i = 1'b0;
    logic       tx_en_set_i = 1'b0, err_clr_i = 1'b0;
    logic [7:0] preload_i = 8'd0;
    logic       tx_en_o, tx_permit_o, err_o;
    logic [7:0] bkoff_cnt_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state: 0 idle, 1 waiting, 2 counting, 3 halted
    int m_state, m_cnt, m_att, m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbk_timer uut (
        .clk(clk), .rst_n(rst_n), .alt_mode_i(alt_mode_i), .coll_i(coll_i),
        .line_idle_i(line_idle_i), .ifs_done_i(ifs_done_i), .fifo_touched_i(fifo_touched_i),
        .slot_tick_i(slot_tick_i), .preload_i(preload_i), .tx_done_i(tx_done_i),
        .tx_en_set_i(tx_en_set_i), .err_clr_i(err_clr_i), .tx_en_o(tx_en_o),
        .tx_permit_o(tx_permit_o), .err_o(err_o), .bkoff_cnt_o(bkoff_cnt_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_att = 0; m_err = 0;
        end else begin
            bit ab, acc;
            ab = 0; acc = 0;
            if (coll_i && m_state != 3) begin
                if (((m_att >> 7) & 1) == 1 || fifo_touched_i) ab = 1; else acc = 1;
                m_att = ((m_att << 1) | 1) & 255;
            end else if (tx_done_i || tx_en_set_i) begin
                m_att = 0;
            end
            if (ab) m_err = 1; else if (err_clr_i) m_err = 0;
            if (ab) begin
                m_state = 3; m_cnt = 0;
            end else if (acc) begin
                m_state = 1; m_cnt = preload_i;
            end else begin
                case (m_state)
                    1: if (alt_mode_i ? ifs_done_i : line_idle_i) m_state = (m_cnt == 0) ? 0 : 2;
                    2: if (slot_tick_i) begin
                           m_cnt = m_cnt - 1;
                           if (m_cnt == 0) m_state = 0;
                       end
                    3: if (tx_en_set_i) m_state = 0;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, away from both clock edges
    always begin
        @(posedge clk);
        #2;
        if (rst_n) begin
            check(bkoff_cnt_o == m_cnt[7:0], "R3 count vs model", bkoff_cnt_o, m_cnt);
            check(tx_en_o == (m_state != 3), "R6 tx_en vs model", tx_en_o, m_state != 3);
            check(err_o == m_err[0], "R8 err vs model", err_o, m_err);
            check(tx_permit_o == (m_state == 0 && ifs_done_i), "R4 permit vs model",
                  tx_permit_o, m_state == 0 && ifs_done_i);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sample;
        @(posedge clk);
        #3;
    endtask

    task automatic pulse_coll(input logic [7:0] pl);
        @(negedge clk); preload_i = pl; coll_i = 1'b1;
        @(negedge clk); coll_i = 1'b0;
    endtask

    task automatic pulse_tick;
        @(negedge clk); slot_tick_i = 1'b1;
        @(negedge clk); slot_tick_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        sample;
        check(tx_en_o == 1 && err_o == 0 && bkoff_cnt_o == 0 && tx_permit_o == 0,
              "R1 reset state", {tx_en_o, err_o, tx_permit_o}, 3'b100);

        // normal mode
        pulse_coll(8'd3);
        check(bkoff_cnt_o == 3, "R2 preload captured", bkoff_cnt_o, 3);
        @(negedge clk); ifs_done_i = 1'b1;
        pulse_tick;
        check(bkoff_cnt_o == 3, "R5 normal mode ignores IFS", bkoff_cnt_o, 3);
        check(tx_permit_o == 0, "R4 blocked while nonzero", tx_permit_o, 0);
        @(negedge clk); line_idle_i = 1'b1;
        @(negedge clk); line_idle_i = 1'b0;
        step(2);
        check(bkoff_cnt_o == 3, "R3 holds without tick", bkoff_cnt_o, 3);
        pulse_tick;
        check(bkoff_cnt_o == 2, "R3 first tick", bkoff_cnt_o, 2);
        @(negedge clk); tx_en_set_i = 1'b1; err_clr_i = 1'b1;
        @(negedge clk); tx_en_set_i = 1'b0; err_clr_i = 1'b0;
        check(bkoff_cnt_o == 2, "R10 no write path", bkoff_cnt_o, 2);
        pulse_tick;
        pulse_tick;
        check(bkoff_cnt_o == 0 && tx_permit_o == 1, "R4 permit at zero", tx_permit_o, 1);

        // reload wins over tick during countdown
        pulse_coll(8'd4);
        @(negedge clk); line_idle_i = 1'b1;
        @(negedge clk); line_idle_i = 1'b0;
        @(negedge clk); slot_tick_i = 1'b1; coll_i = 1'b1; preload_i = 8'd6;
        @(negedge clk); slot_tick_i = 1'b0; coll_i = 1'b0;
        check(bkoff_cnt_o == 6, "R2 reload during count", bkoff_cnt_o, 6);
        @(negedge clk); line_idle_i = 1'b1;
        @(negedge clk); line_idle_i = 1'b0;
        repeat (6) pulse_tick;
        check(bkoff_cnt_o == 0, "R3 reaches zero", bkoff_cnt_o, 0);

        // alternate mode
        @(negedge clk); alt_mode_i = 1'b1; ifs_done_i = 1'b0; line_idle_i = 1'b1;
        pulse_coll(8'd2);
        pulse_tick;
        check(bkoff_cnt_o == 2, "R5 alt mode ignores line idle", bkoff_cnt_o, 2);
        @(negedge clk); ifs_done_i = 1'b1;
        @(negedge clk); ifs_done_i = 1'b0;
        pulse_tick;
        check(bkoff_cnt_o == 1, "R5 alt mode starts after IFS", bkoff_cnt_o, 1);
        pulse_tick;
        @(negedge clk); line_idle_i = 1'b0;

        // alternate mode, preload zero
        pulse_coll(8'd0);
        @(negedge clk); ifs_done_i = 1'b1;
        #2;
        check(tx_permit_o == 0, "R11 not before IFS sampled", tx_permit_o, 0);
        sample;
        check(tx_permit_o == 1, "R11 permit first cycle after IFS", tx_permit_o, 1);
        @(negedge clk); ifs_done_i = 1'b0; alt_mode_i = 1'b0;

        // attempt overflow; last collision coincides with tx_done
        @(negedge clk); tx_done_i = 1'b1;
        @(negedge clk); tx_done_i = 1'b0;
        repeat (7) pulse_coll(8'd1);
        @(negedge clk); tx_done_i = 1'b1; coll_i = 1'b1;
        @(negedge clk); tx_done_i = 1'b0; coll_i = 1'b0;
        check(tx_en_o == 1, "R9 eight collisions tolerated", tx_en_o, 1);
        pulse_coll(8'd1);
        check(tx_en_o == 0 && err_o == 1 && bkoff_cnt_o == 0, "R6 ninth collision aborts",
              {tx_en_o, err_o}, 2'b01);
        pulse_coll(8'd5);
        check(bkoff_cnt_o == 0 && tx_en_o == 0, "R6 collision ignored when halted", bkoff_cnt_o, 0);
        step(3);
        check(err_o == 1, "R8 error sticky", err_o, 1);
        @(negedge clk); err_clr_i = 1'b1;
        @(negedge clk); err_clr_i = 1'b0;
        check(err_o == 0, "R8 error cleared", err_o, 0);
        @(negedge clk); tx_en_set_i = 1'b1;
        @(negedge clk); tx_en_set_i = 1'b0;
        check(tx_en_o == 1, "R9 re-enable", tx_en_o, 1);

        // history clear by tx_done
        repeat (8) pulse_coll(8'd0);
        @(negedge clk); tx_done_i = 1'b1;
        @(negedge clk); tx_done_i = 1'b0;
        repeat (8) pulse_coll(8'd0);
        check(tx_en_o == 1 && err_o == 0, "R9 tx_done clears history", tx_en_o, 1);

        // FIFO abort with simultaneous clear
        @(negedge clk); tx_done_i = 1'b1;
        @(negedge clk); tx_done_i = 1'b0; fifo_touched_i = 1'b1; coll_i = 1'b1; err_clr_i = 1'b1;
        @(negedge clk); fifo_touched_i = 1'b0; coll_i = 1'b0; err_clr_i = 1'b0;
        check(tx_en_o == 0 && err_o == 1, "R7 FIFO abort, R8 set wins", {tx_en_o, err_o}, 2'b01);
        @(negedge clk); tx_en_set_i = 1'b1; err_clr_i = 1'b1;
        @(negedge clk); tx_en_set_i = 1'b0; err_clr_i = 1'b0;
        check(tx_en_o == 1 && err_o == 0, "R9 recovery after FIFO abort", {tx_en_o, err_o}, 2'b10);

        step(3);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule